// File: doc/BRIEF.md
# Fully Associative Page Translator

This block turns a 32-bit logical address into a 24-bit physical address through a 64-entry, fully associative table of 4 KB pages. Each table entry holds a 20-bit logical page tag, a 12-bit physical page number, a write-protect flag, an execute-only flag and a valid flag. The low 12 address bits always pass through unchanged. Accesses in supervisor state, or in user state while the bypass mode bit is set, go through untranslated. A mapped user access that misses, writes a write-protected page, or does anything other than an instruction fetch to an execute-only page raises a bus error. It also records the cause, the entry index and the faulting address.

Software runs the table through a small register port. It reads the fault record and the address latch, then writes a physical entry. That write loads the entry's tag from the latch, so the faulting page is installed without composing a tag by hand. After that the suspended access can be retried.

A two-state cycle machine registers the result once per address strobe. State `ST_IDLE` takes transition `T_START` to `ST_HOLD` on the first clock edge that sees the strobe high. At that edge it registers the physical address and the bus error, and captures any fault. State `ST_HOLD` takes transition `T_END` back to `ST_IDLE` on the first edge that sees the strobe low, and clears the bus error there.

Top module: `page_xlate_top`

## Requirements
- R1: A mapped user access (fcode[2]=0, mode bit 0) whose bits 31:12 match a valid entry yields paddr = {that entry's physical page, laddr[11:0]} with bus_err low, unless R6 or R7 applies. In every case paddr[11:0] equals laddr[11:0].
- R2: When several valid entries hold the same tag, the entry with the lowest index is used.
- R3: With fcode[2]=1 (supervisor), paddr = laddr[23:0] and bus_err stays low, whatever the table holds.
- R4: In user state with the mode bit set, paddr = laddr[23:0] and bus_err stays low. The mode bit is bit 16 of the status word at reg_addr 0x80. A write there sets the mode bit from reg_wdata[16] and clears both violation flags.
- R5: A mapped user access matching no valid entry asserts bus_err with paddr = {12'h000, laddr[11:0]}. Both violation flags (status bits 31 and 30) read as 0 afterwards.
- R6: A mapped user write (rd_nwr=0) hitting an entry with write-protect set asserts bus_err. It sets status bit 31 and puts the entry index in status bits 5:0. Reads of that page are allowed.
- R7: A mapped user access hitting an entry with execute-only set asserts bus_err, unless fcode[1:0]=2'b10 (program space). It sets status bit 30 and records the index in bits 5:0.
- R8: Every faulting access copies the full 32-bit logical address into the address latch at reg_addr 0x81. Software may also write that latch.
- R9: Writing a physical entry (reg_addr 0x40+index, reg_wdata[11:0] page, [12] write-protect, [13] execute-only) also loads that entry's tag from latch bits 31:12 and marks it valid. A read of that address returns the fields with valid in bit 14. A tag entry (reg_addr 0x00+index) can be written and read directly in bits 19:0.
- R10: paddr and bus_err update at the first clock edge that sees lstrobe high in the idle state. They hold while lstrobe stays high, whatever the inputs do. bus_err clears at the first edge that sees lstrobe low.
- R11: After reset, paddr is 0, bus_err is 0, the status word reads 0, and every entry is invalid, so any mapped user access misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lstrobe | input | 1 | Logical address strobe; qualifies an access |
| laddr | input | 32 | Logical address |
| fcode | input | 3 | Function code; bit 2 = supervisor, 2'b10 in bits 1:0 = program space |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| paddr | output | 24 | Registered physical address |
| bus_err | output | 1 | Registered bus error |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 8 | Register address (00-3F tags, 40-7F physical entries, 80 status, 81 latch) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |

## Verification
A corrupted tag or physical field shows at the ports one clock after the next strobe that touches the page. It appears as a wrong physical page or a spurious miss. A cycle machine stuck in the wrong state shows up as paddr changing during a held strobe, or as bus_err surviving the strobe's fall by more than one edge. A fault record or latch that captured the wrong data is visible right away through the combinational register read. A refill that loads the wrong tag turns the retried access into a second miss.

// File: rtl/pxl_pkg.sv
package pxl_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } cyc_state_e;

    typedef enum logic [1:0] {
        RG_TAG  = 2'b00,
        RG_PHYS = 2'b01,
        RG_CTRL = 2'b10,
        RG_NONE = 2'b11
    } reg_region_e;

    localparam logic [1:0] FC_PROGRAM = 2'b10;

endpackage

// File: rtl/pxl_table.sv
module pxl_table #(
    parameter int ENTRIES = 64,
    parameter int TAG_W   = 20,
    parameter int PPN_W   = 12,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TAG_W-1:0]   lk_tag,
    output logic               hit,
    output logic [IDX_W-1:0]   hit_idx,
    output logic [PPN_W-1:0]   hit_ppn,
    output logic               hit_wp,
    output logic               hit_ep,
    input  logic               tag_we,
    input  logic               phys_we,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [TAG_W-1:0]   tag_wdata,
    input  logic [PPN_W-1:0]   ppn_wdata,
    input  logic               wp_wdata,
    input  logic               ep_wdata,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [TAG_W-1:0]   rd_tag,
    output logic [PPN_W-1:0]   rd_ppn,
    output logic               rd_wp,
    output logic               rd_ep,
    output logic               rd_vld
);

    logic [TAG_W-1:0] tag_q [ENTRIES];
    logic [PPN_W-1:0] ppn_q [ENTRIES];
    logic [ENTRIES-1:0] wp_q, ep_q, vld_q, match_vec;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tag_q[g] <= '0;
                ppn_q[g] <= '0;
                wp_q[g]  <= 1'b0;
                ep_q[g]  <= 1'b0;
                vld_q[g] <= 1'b0;
            end else if (phys_we && wr_idx == IDX_W'(g)) begin
                tag_q[g] <= tag_wdata;
                ppn_q[g] <= ppn_wdata;
                wp_q[g]  <= wp_wdata;
                ep_q[g]  <= ep_wdata;
                vld_q[g] <= 1'b1;
            end else if (tag_we && wr_idx == IDX_W'(g)) begin
                tag_q[g] <= tag_wdata;
            end
        end
        assign match_vec[g] = vld_q[g] && (tag_q[g] == lk_tag);
    end

    // Lowest matching index wins.
    always_comb begin
        hit_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match_vec[i]) hit_idx = IDX_W'(i);
        end
    end

    assign hit     = |match_vec;
    assign hit_ppn = ppn_q[hit_idx];
    assign hit_wp  = wp_q[hit_idx];
    assign hit_ep  = ep_q[hit_idx];

    assign rd_tag  = tag_q[rd_idx];
    assign rd_ppn  = ppn_q[rd_idx];
    assign rd_wp   = wp_q[rd_idx];
    assign rd_ep   = ep_q[rd_idx];
    assign rd_vld  = vld_q[rd_idx];

endmodule

// File: rtl/pxl_status.sv
module pxl_status #(
    parameter int LA_W  = 32,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic             wp_viol,
    input  logic             ep_viol,
    input  logic [IDX_W-1:0] flt_idx,
    input  logic [LA_W-1:0]  flt_addr,
    input  logic             st_we,
    input  logic             lt_we,
    input  logic [31:0]      wdata,
    output logic             mode,
    output logic             wp_flag,
    output logic             ep_flag,
    output logic [IDX_W-1:0] idx_rec,
    output logic [LA_W-1:0]  latch
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode    <= 1'b0;
            wp_flag <= 1'b0;
            ep_flag <= 1'b0;
            idx_rec <= '0;
            latch   <= '0;
        end else begin
            if (st_we) mode <= wdata[16];
            if (capture) begin
                wp_flag <= wp_viol;
                ep_flag <= ep_viol;
                idx_rec <= flt_idx;
                latch   <= flt_addr;
            end else begin
                if (st_we) begin
                    wp_flag <= 1'b0;
                    ep_flag <= 1'b0;
                end
                if (lt_we) latch <= LA_W'(wdata);
            end
        end
    end

endmodule

// File: rtl/pxl_cycle.sv
module pxl_cycle
    import pxl_pkg::*;
#(
    parameter int PA_W = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lstrobe,
    input  logic [PA_W-1:0] nxt_paddr,
    input  logic            nxt_fault,
    output logic [PA_W-1:0] paddr,
    output logic            bus_err,
    output logic            start,
    output logic            idle
);

    cyc_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (lstrobe)  state_d = ST_HOLD;  // T_START
            ST_HOLD: if (!lstrobe) state_d = ST_IDLE;  // T_END
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign idle  = (state_q == ST_IDLE);
    assign start = idle && lstrobe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            paddr   <= '0;
            bus_err <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (lstrobe) begin
                    paddr   <= nxt_paddr;
                    bus_err <= nxt_fault;
                end
                ST_HOLD: if (!lstrobe) bus_err <= 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/page_xlate_top.sv
module page_xlate_top
    import pxl_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int LA_W    = 32,
    parameter int PA_W    = 24,
    parameter int OFF_W   = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lstrobe,
    input  logic [LA_W-1:0]      laddr,
    input  logic [2:0]           fcode,
    input  logic                 rd_nwr,
    output logic [PA_W-1:0]      paddr,
    output logic                 bus_err,
    input  logic                 reg_wr,
    input  logic [$clog2(ENTRIES)+1:0] reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata
);

    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = LA_W - OFF_W;
    localparam int PPN_W = PA_W - OFF_W;

    logic             hit, hit_wp, hit_ep;
    logic [IDX_W-1:0] hit_idx;
    logic [PPN_W-1:0] hit_ppn;
    logic [TAG_W-1:0] rd_tag;
    logic [PPN_W-1:0] rd_ppn;
    logic             rd_wp, rd_ep, rd_vld;
    logic             mode, wp_flag, ep_flag;
    logic [IDX_W-1:0] idx_rec;
    logic [LA_W-1:0]  latch;
    logic             start, cyc_idle;

    reg_region_e      region;
    logic [IDX_W-1:0] reg_idx;
    logic             tag_we, phys_we, st_we, lt_we;

    assign region  = reg_region_e'(reg_addr[IDX_W+1:IDX_W]);
    assign reg_idx = reg_addr[IDX_W-1:0];
    assign tag_we  = reg_wr && region == RG_TAG;
    assign phys_we = reg_wr && region == RG_PHYS;
    assign st_we   = reg_wr && region == RG_CTRL && !reg_addr[0];
    assign lt_we   = reg_wr && region == RG_CTRL &&  reg_addr[0];

    logic [TAG_W-1:0] tag_wdata;
    assign tag_wdata = phys_we ? latch[LA_W-1:OFF_W] : reg_wdata[TAG_W-1:0];

    pxl_table #(
        .ENTRIES(ENTRIES), .TAG_W(TAG_W), .PPN_W(PPN_W), .IDX_W(IDX_W)
    ) u_table (
        .clk(clk), .rst_n(rst_n),
        .lk_tag(laddr[LA_W-1:OFF_W]),
        .hit(hit), .hit_idx(hit_idx), .hit_ppn(hit_ppn),
        .hit_wp(hit_wp), .hit_ep(hit_ep),
        .tag_we(tag_we), .phys_we(phys_we), .wr_idx(reg_idx),
        .tag_wdata(tag_wdata),
        .ppn_wdata(reg_wdata[PPN_W-1:0]),
        .wp_wdata(reg_wdata[PPN_W]), .ep_wdata(reg_wdata[PPN_W+1]),
        .rd_idx(reg_idx), .rd_tag(rd_tag), .rd_ppn(rd_ppn),
        .rd_wp(rd_wp), .rd_ep(rd_ep), .rd_vld(rd_vld)
    );

    // Lookup and protection checks
    logic mapped, fetch, miss, wp_viol, ep_viol, fault;
    logic [PA_W-1:0] nxt_paddr;

    assign mapped  = !fcode[2] && !mode;
    assign fetch   = (fcode[1:0] == FC_PROGRAM);
    assign miss    = mapped && !hit;
    assign wp_viol = mapped && hit && hit_wp && !rd_nwr;
    assign ep_viol = mapped && hit && hit_ep && !fetch;
    assign fault   = miss || wp_viol || ep_viol;

    always_comb begin
        if (!mapped)  nxt_paddr = laddr[PA_W-1:0];
        else if (hit) nxt_paddr = {hit_ppn, laddr[OFF_W-1:0]};
        else          nxt_paddr = {{PPN_W{1'b0}}, laddr[OFF_W-1:0]};
    end

    pxl_cycle #(.PA_W(PA_W)) u_cycle (
        .clk(clk), .rst_n(rst_n), .lstrobe(lstrobe),
        .nxt_paddr(nxt_paddr), .nxt_fault(fault),
        .paddr(paddr), .bus_err(bus_err),
        .start(start), .idle(cyc_idle)
    );

    pxl_status #(.LA_W(LA_W), .IDX_W(IDX_W)) u_status (
        .clk(clk), .rst_n(rst_n),
        .capture(start && fault),
        .wp_viol(wp_viol), .ep_viol(ep_viol),
        .flt_idx(hit_idx), .flt_addr(laddr),
        .st_we(st_we), .lt_we(lt_we), .wdata(reg_wdata),
        .mode(mode), .wp_flag(wp_flag), .ep_flag(ep_flag),
        .idx_rec(idx_rec), .latch(latch)
    );

    // Register read mux
    always_comb begin
        reg_rdata = '0;
        unique case (region)
            RG_TAG:  reg_rdata[TAG_W-1:0] = rd_tag;
            RG_PHYS: begin
                reg_rdata[PPN_W-1:0] = rd_ppn;
                reg_rdata[PPN_W]     = rd_wp;
                reg_rdata[PPN_W+1]   = rd_ep;
                reg_rdata[PPN_W+2]   = rd_vld;
            end
            RG_CTRL: begin
                if (reg_addr[0]) begin
                    reg_rdata = 32'(latch);
                end else begin
                    reg_rdata[31]          = wp_flag;
                    reg_rdata[30]          = ep_flag;
                    reg_rdata[16]          = mode;
                    reg_rdata[IDX_W-1:0]   = idx_rec;
                end
            end
            RG_NONE: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/pxl_chk.sv
module pxl_chk #(
    parameter int LA_W  = 32,
    parameter int PA_W  = 24,
    parameter int OFF_W = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            lstrobe,
    input logic [2:0]      fcode,
    input logic [LA_W-1:0] laddr,
    input logic [PA_W-1:0] paddr,
    input logic            bus_err,
    input logic            mode,
    input logic            cyc_idle,
    input logic [LA_W-1:0] latch
);

    a_r1_offset_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_idle && lstrobe) |=> paddr[OFF_W-1:0] == $past(laddr[OFF_W-1:0]));

    a_r3_super_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_idle && lstrobe && fcode[2])
        |=> (!bus_err && paddr == $past(laddr[PA_W-1:0])));

    a_r4_mode_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_idle && lstrobe && !fcode[2] && mode)
        |=> (!bus_err && paddr == $past(laddr[PA_W-1:0])));

    a_r8_latch_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_err) |-> latch == $past(laddr));

    a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_idle && lstrobe) |=> ($stable(paddr) && $stable(bus_err)));

    a_r10_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_idle && !lstrobe) |=> !bus_err);

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_idle |-> !bus_err);

endmodule

bind page_xlate_top pxl_chk #(.LA_W(LA_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .lstrobe(lstrobe), .fcode(fcode),
    .laddr(laddr), .paddr(paddr), .bus_err(bus_err), .mode(mode),
    .cyc_idle(cyc_idle), .latch(latch)
);

// File: tb/page_xlate_top_tb_top.sv
module page_xlate_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lstrobe = 1'b0;
    logic [31:0] laddr = '0;
    logic [2:0]  fcode = '0;
    logic        rd_nwr = 1'b1;
    logic [23:0] paddr;
    logic        bus_err;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    page_xlate_top dut_i (
        .clk(clk), .rst_n(rst_n), .lstrobe(lstrobe), .laddr(laddr),
        .fcode(fcode), .rd_nwr(rd_nwr), .paddr(paddr), .bus_err(bus_err),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    // One strobe: outputs checked after the capturing edge, then after the release edge.
    task automatic access(input string req, input logic [31:0] la, input logic [2:0] fc,
                          input logic rnw, input logic [23:0] exp_pa, input logic exp_err);
        @(negedge clk);
        lstrobe = 1'b1; laddr = la; fcode = fc; rd_nwr = rnw;
        @(negedge clk);
        chk({req, " paddr"}, 32'(paddr), 32'(exp_pa));
        chk({req, " bus_err"}, 32'(bus_err), 32'(exp_err));
        lstrobe = 1'b0;
        @(negedge clk);
        chk("R10 err clear", 32'(bus_err), 32'h0);
    endtask

    typedef struct packed {
        logic [31:0] la;
        logic [2:0]  fc;
        logic        rnw;
        logic [23:0] pa;
        logic        err;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VECS [11] = '{
        '{32'h1234_5678, 3'b001, 1'b1, 24'hABC678, 1'b0, 4'd1},  // R1 read
        '{32'h1234_5FFF, 3'b001, 1'b0, 24'hABCFFF, 1'b0, 4'd1},  // R1 write
        '{32'h0001_0123, 3'b001, 1'b1, 24'h111123, 1'b0, 4'd6},  // R6 read allowed
        '{32'h0001_0123, 3'b001, 1'b0, 24'h111123, 1'b1, 4'd6},  // R6 violation
        '{32'h0002_0ABC, 3'b010, 1'b1, 24'h222ABC, 1'b0, 4'd7},  // R7 fetch ok
        '{32'h0002_0ABC, 3'b001, 1'b1, 24'h222ABC, 1'b1, 4'd7},  // R7 data violation
        '{32'h0003_0010, 3'b001, 1'b1, 24'h444010, 1'b0, 4'd2},  // R2 lowest index
        '{32'h0006_0020, 3'b001, 1'b1, 24'h666020, 1'b0, 4'd9},  // R9 direct tag
        '{32'h0005_0020, 3'b001, 1'b1, 24'h000020, 1'b1, 4'd5},  // R5 miss
        '{32'hFFAB_C123, 3'b101, 1'b0, 24'hABC123, 1'b0, 4'd3},  // R3 super write
        '{32'h7777_7777, 3'b110, 1'b1, 24'h777777, 1'b0, 4'd3}   // R3 super fetch
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 paddr", 32'(paddr), 32'h0);
        chk("R11 bus_err", 32'(bus_err), 32'h0);
        rst_n = 1'b1;
        reg_read("R11 status", 8'h80, 32'h0);
        reg_read("R11 phys entry", 8'h40, 32'h0);
        access("R11 empty miss", 32'h0000_0123, 3'b001, 1'b1, 24'h000123, 1'b1);

        // Table setup through the latch (R8 write, R9 refill)
        reg_write(8'h81, 32'h1234_5000); reg_write(8'h40, 32'h0000_0ABC);
        reg_write(8'h81, 32'h0001_0000); reg_write(8'h41, 32'h0000_1111);
        reg_write(8'h81, 32'h0002_0000); reg_write(8'h42, 32'h0000_2222);
        reg_write(8'h81, 32'h0003_0000); reg_write(8'h45, 32'h0000_0555);
        reg_write(8'h44, 32'h0000_0444);
        reg_write(8'h81, 32'h0005_0000); reg_write(8'h46, 32'h0000_0666);
        reg_write(8'h06, 32'h0000_0060);
        reg_read("R9 tag from latch", 8'h00, 32'h0001_2345);
        reg_read("R9 phys readback", 8'h41, 32'h0000_5111);
        reg_read("R9 direct tag", 8'h06, 32'h0000_0060);

        for (int i = 0; i < 11; i++) begin
            access($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].la, VECS[i].fc,
                   VECS[i].rnw, VECS[i].pa, VECS[i].err);
        end

        // Fault records
        access("R6 wp", 32'h0001_0123, 3'b001, 1'b0, 24'h111123, 1'b1);
        reg_read("R6 status", 8'h80, 32'h8000_0001);
        reg_read("R8 latch", 8'h81, 32'h0001_0123);
        access("R7 ep", 32'h0002_0ABC, 3'b000, 1'b0, 24'h222ABC, 1'b1);
        reg_read("R7 status", 8'h80, 32'h4000_0002);
        access("R5 miss", 32'h0005_0020, 3'b001, 1'b1, 24'h000020, 1'b1);
        @(negedge clk); reg_addr = 8'h80; #1;
        chk("R5 flags", 32'(reg_rdata[31:30]), 32'h0);
        reg_read("R8 latch miss", 8'h81, 32'h0005_0020);

        // R9 refill and retry
        reg_write(8'h47, 32'h0000_0777);
        access("R9 retry", 32'h0005_0020, 3'b001, 1'b1, 24'h777020, 1'b0);

        // R4 mode bypass
        reg_write(8'h80, 32'h0001_0000);
        reg_read("R4 mode bit", 8'h80, 32'h0001_0000);
        access("R4 bypass", 32'h0009_9ABC, 3'b001, 1'b0, 24'h099ABC, 1'b0);
        reg_write(8'h80, 32'h0000_0000);
        access("R4 mapped again", 32'h0009_9ABC, 3'b001, 1'b1, 24'h000ABC, 1'b1);

        // R10 hold: inputs change while strobe high
        @(negedge clk);
        lstrobe = 1'b1; laddr = 32'h1234_5678; fcode = 3'b001; rd_nwr = 1'b1;
        @(negedge clk);
        laddr = 32'h0005_0000; rd_nwr = 1'b0; fcode = 3'b101;
        @(negedge clk);
        chk("R10 hold paddr", 32'(paddr), 32'h00AB_C678);
        chk("R10 hold err", 32'(bus_err), 32'h0);
        lstrobe = 1'b0;
        @(negedge clk);

        // R10 error held during strobe
        @(negedge clk);
        lstrobe = 1'b1; laddr = 32'h00AA_A000; fcode = 3'b001; rd_nwr = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R10 err held", 32'(bus_err), 32'h1);
        lstrobe = 1'b0;
        @(negedge clk);
        chk("R10 err released", 32'(bus_err), 32'h0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule